// File: doc/BRIEF.md
# DMA Channel Count and Address Sequencer

This block keeps the running state of one DMA channel: how much work remains and which memory address the next data unit uses. Software writes a small set of configuration registers through a write-only port. A start pulse loads the working counters and the address from those registers. After that, every pulse on the transfer-complete strobe moves the address by the data size of that transfer and counts the unit off. The actual bus traffic, arbitration and request handshaking belong to neighbouring logic.

The same 24 bits of count configuration are read two ways. In block mode they are an 8-bit units-per-block length plus a 16-bit number of blocks. In the single-unit and back-to-back modes they form one 24-bit unit count. A global advanced-address bit, latched at start, selects between a 28-bit address built from the standard pair of registers and a full 32-bit address built from a separate pair.

Top module: `dma_chan_seq`

## Requirements
- R1: After reset, `cur_addr` is 0 and `busy`, `blk_done`, `chan_done` and `cfg_err` are all 0.
- R2: Config register 2 holds address bits 15:0 and register 3 bits [11:0] hold address bits 27:16 of the standard address. Registers 4 and 5 hold the low and high halves of the advanced address. Register 6 bit 0 selects advanced addressing. An accepted start shows the selected address on `cur_addr` from the next cycle, with bits 31:28 zero in standard mode.
- R3: Register 1 bits [11:10] give address control: 01 adds the step, 10 subtracts it, and 00 or 11 holds the address. `xfer_size` 00, 01 and 10/11 give steps of 1, 2 and 4 bytes. The new address appears the cycle after a counted strobe.
- R4: Address arithmetic wraps at 2^28 in standard mode and at 2^32 in advanced mode.
- R5: Register 1 bits [9:8] give the mode: 00 single, 01 or 11 back-to-back, 10 block. Outside block mode the unit count is {reg1[7:0], reg0[15:8], reg0[7:0]}, and `chan_done` rises after exactly that many counted strobes.
- R6: In block mode, reg0[7:0] is the units per block and {reg1[7:0], reg0[15:8]} is the block count. `blk_done` pulses for one cycle after each block's last unit. On the final unit it pulses in the same cycle that `chan_done` rises.
- R7: A start is refused when it would give no work: block mode with a zero block length or a zero block count, or any other mode with a zero unit count. A refused start sets `cfg_err` and leaves `busy` low. The next accepted start clears `cfg_err`.
- R8: In single mode, `busy` falls after each counted unit. The next start resumes without reloading, and the address continues from where it stopped.
- R9: In back-to-back and block modes, `busy` stays high from the accepted start until the last unit has been counted.
- R10: A strobe while `busy` is low does not change the address. A start while `busy` is high is ignored.
- R11: `chan_done` stays set while the channel is idle after completion, and is cleared by the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 3 | Configuration register select |
| cfg_wdata | input | 16 | Configuration write data |
| start | input | 1 | Start or resume pulse |
| xfer_done | input | 1 | One data unit has completed |
| xfer_size | input | 2 | Size of the completed unit (00 byte, 01 half, 10/11 word) |
| cur_addr | output | 32 | Address for the next unit |
| busy | output | 1 | Channel is counting transfers |
| blk_done | output | 1 | One-cycle pulse at the end of a block |
| chan_done | output | 1 | All programmed work finished |
| cfg_err | output | 1 | Last start was refused for zero work |

## Verification
In block mode, the end of a block and the end of the whole channel fall in the same cycle when the last unit of the last block is counted. Many block-mode runs with varied block lengths and counts drive the strobe through that final unit. After every unit, both flags are compared against a model that derives block boundaries from the unit index and the total. A second coincidence, a start arriving while the channel runs, is injected at random and must leave the address and `busy` unchanged.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

   typedef enum logic [1:0] {
      XM_SINGLE = 2'b00,
      XM_SUCC   = 2'b01,
      XM_BLOCK  = 2'b10,
      XM_SUCC_B = 2'b11
   } xmode_e;

   typedef enum logic [1:0] {
      AC_HOLD   = 2'b00,
      AC_INC    = 2'b01,
      AC_DEC    = 2'b10,
      AC_HOLD_B = 2'b11
   } actl_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'b00,
      ST_RUN  = 2'b01,
      ST_WAIT = 2'b10
   } chst_e;

endpackage

// File: rtl/dma_seq_cfg.sv
module dma_seq_cfg #(
   parameter int DW     = 16,
   parameter int LEN_W  = 8,
   parameter int STD_AW = 28,
   parameter int ADV_AW = 32,
   parameter int AW     = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [AW-1:0]     addr,
   input  logic [DW-1:0]     wdata,
   output logic [LEN_W-1:0]  blen,
   output logic [LEN_W-1:0]  cnt_mid,
   output logic [LEN_W-1:0]  cnt_hi,
   output logic [1:0]        mode,
   output logic [1:0]        actl,
   output logic [ADV_AW-1:0] std_addr,
   output logic [ADV_AW-1:0] adv_addr,
   output logic              adv_en
);
   localparam int STD_HI_W = STD_AW - DW;
   localparam int ADV_HI_W = ADV_AW - DW;
   localparam int CTL_W    = LEN_W + 4;

   localparam logic [AW-1:0] A_LEN = AW'(0);
   localparam logic [AW-1:0] A_CTL = AW'(1);
   localparam logic [AW-1:0] A_SLO = AW'(2);
   localparam logic [AW-1:0] A_SHI = AW'(3);
   localparam logic [AW-1:0] A_ALO = AW'(4);
   localparam logic [AW-1:0] A_AHI = AW'(5);
   localparam logic [AW-1:0] A_GLB = AW'(6);

   logic [2*LEN_W-1:0]  len_q;
   logic [CTL_W-1:0]    ctl_q;
   logic [DW-1:0]       slo_q, alo_q;
   logic [STD_HI_W-1:0] shi_q;
   logic [ADV_HI_W-1:0] ahi_q;
   logic                adv_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         len_q <= '0;
         ctl_q <= '0;
         slo_q <= '0;
         shi_q <= '0;
         alo_q <= '0;
         ahi_q <= '0;
         adv_q <= 1'b0;
      end else if (we) begin
         case (addr)
            A_LEN:   len_q <= wdata[2*LEN_W-1:0];
            A_CTL:   ctl_q <= wdata[CTL_W-1:0];
            A_SLO:   slo_q <= wdata;
            A_SHI:   shi_q <= wdata[STD_HI_W-1:0];
            A_ALO:   alo_q <= wdata;
            A_AHI:   ahi_q <= wdata[ADV_HI_W-1:0];
            A_GLB:   adv_q <= wdata[0];
            default: ;
         endcase
      end
   end

   assign blen     = len_q[LEN_W-1:0];
   assign cnt_mid  = len_q[2*LEN_W-1:LEN_W];
   assign cnt_hi   = ctl_q[LEN_W-1:0];
   assign mode     = ctl_q[LEN_W+1:LEN_W];
   assign actl     = ctl_q[LEN_W+3:LEN_W+2];
   assign adv_addr = {ahi_q, alo_q};
   assign adv_en   = adv_q;

   always_comb begin
      std_addr               = '0;
      std_addr[STD_AW-1:0]   = {shi_q, slo_q};
   end

endmodule

// File: rtl/dma_seq_cnt.sv
module dma_seq_cnt #(
   parameter int LEN_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             blk_mode,
   input  logic [LEN_W-1:0] blen,
   input  logic [LEN_W-1:0] cnt_mid,
   input  logic [LEN_W-1:0] cnt_hi,
   input  logic             step,
   output logic             zero_cfg,
   output logic             blk_end,
   output logic             last_unit
);
   localparam int CNT_W = 3 * LEN_W;

   logic [CNT_W-1:0] rem_q;
   logic [LEN_W-1:0] len_q, reload_q;
   logic             blk_q;

   assign zero_cfg = blk_mode ? ((blen == '0) || ({cnt_hi, cnt_mid} == '0))
                              : ({cnt_hi, cnt_mid, blen} == '0);

   assign blk_end   = blk_q && (len_q == LEN_W'(1));
   assign last_unit = (rem_q == CNT_W'(1)) && (!blk_q || (len_q == LEN_W'(1)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q    <= '0;
         len_q    <= '0;
         reload_q <= '0;
         blk_q    <= 1'b0;
      end else if (load) begin
         blk_q    <= blk_mode;
         reload_q <= blen;
         len_q    <= blen;
         rem_q    <= blk_mode ? {{LEN_W{1'b0}}, cnt_hi, cnt_mid}
                              : {cnt_hi, cnt_mid, blen};
      end else if (step) begin
         if (!blk_q) begin
            rem_q <= rem_q - CNT_W'(1);
         end else if (len_q == LEN_W'(1)) begin
            len_q <= reload_q;
            rem_q <= rem_q - CNT_W'(1);
         end else begin
            len_q <= len_q - LEN_W'(1);
         end
      end
   end

   // R6: while blocks remain, the unit counter never sits at zero
   p_len_live_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (blk_q && rem_q != '0) |-> (len_q != '0));

endmodule

// File: rtl/dma_seq_addr.sv
module dma_seq_addr
   import dma_seq_pkg::*;
#(
   parameter int STD_AW = 28,
   parameter int ADV_AW = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADV_AW-1:0] ld_addr,
   input  logic              ld_adv,
   input  logic              step,
   input  logic [1:0]        actl,
   input  logic [1:0]        xsize,
   output logic [ADV_AW-1:0] addr_q
);
   logic              adv_q;
   logic [ADV_AW-1:0] stepv, sum, nxt;

   always_comb begin
      case (xsize)
         2'b00:   stepv = ADV_AW'(1);
         2'b01:   stepv = ADV_AW'(2);
         default: stepv = ADV_AW'(4);
      endcase
   end

   always_comb begin
      case (actl_e'(actl))
         AC_INC:  sum = addr_q + stepv;
         AC_DEC:  sum = addr_q - stepv;
         default: sum = addr_q;
      endcase
   end

   generate
      if (ADV_AW > STD_AW) begin : g_narrow
         always_comb begin
            nxt = sum;
            if (!adv_q) nxt[ADV_AW-1:STD_AW] = '0;
         end
         // R4: standard addressing never leaves the low address window
         p_std_high_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (!adv_q) |-> (addr_q[ADV_AW-1:STD_AW] == '0));
      end else begin : g_full
         assign nxt = sum;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         adv_q  <= 1'b0;
      end else if (load) begin
         addr_q <= ld_addr;
         adv_q  <= ld_adv;
      end else if (step) begin
         addr_q <= nxt;
      end
   end

endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
   import dma_seq_pkg::*;
#(
   parameter int DW     = 16,
   parameter int LEN_W  = 8,
   parameter int STD_AW = 28,
   parameter int ADV_AW = 32,
   parameter int CFG_AW = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [CFG_AW-1:0] cfg_addr,
   input  logic [DW-1:0]     cfg_wdata,
   input  logic              start,
   input  logic              xfer_done,
   input  logic [1:0]        xfer_size,
   output logic [ADV_AW-1:0] cur_addr,
   output logic              busy,
   output logic              blk_done,
   output logic              chan_done,
   output logic              cfg_err
);
   generate
      if (DW < 2 * LEN_W)     begin : g_bad_dw  $error("count fields exceed register width"); end
      if (LEN_W < 4)          begin : g_bad_len $error("length field too narrow for control bits"); end
      if (STD_AW <= DW)       begin : g_bad_std $error("standard address must exceed one register"); end
      if (ADV_AW > 2 * DW)    begin : g_bad_adv $error("advanced address exceeds two registers"); end
      if (STD_AW > ADV_AW)    begin : g_bad_ord $error("standard address wider than advanced"); end
      if (CFG_AW < 3)         begin : g_bad_cfg $error("config select too narrow"); end
   endgenerate

   logic [LEN_W-1:0]  c_blen, c_mid, c_hi;
   logic [1:0]        c_mode, c_actl;
   logic [ADV_AW-1:0] c_std, c_adv, ld_addr;
   logic              c_adv_en;
   logic              zero_cfg, blk_end, last_unit;
   logic              start_ok, step;

   chst_e  st_q;
   xmode_e mode_q;
   logic   done_q, err_q, blkd_q;

   dma_seq_cfg #(.DW(DW), .LEN_W(LEN_W), .STD_AW(STD_AW), .ADV_AW(ADV_AW), .AW(CFG_AW)) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (cfg_we),
      .addr     (cfg_addr),
      .wdata    (cfg_wdata),
      .blen     (c_blen),
      .cnt_mid  (c_mid),
      .cnt_hi   (c_hi),
      .mode     (c_mode),
      .actl     (c_actl),
      .std_addr (c_std),
      .adv_addr (c_adv),
      .adv_en   (c_adv_en)
   );

   assign start_ok = start && (st_q == ST_IDLE) && !zero_cfg;
   assign step     = xfer_done && (st_q == ST_RUN);
   assign ld_addr  = c_adv_en ? c_adv : c_std;

   dma_seq_cnt #(.LEN_W(LEN_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (start_ok),
      .blk_mode  (c_mode == XM_BLOCK),
      .blen      (c_blen),
      .cnt_mid   (c_mid),
      .cnt_hi    (c_hi),
      .step      (step),
      .zero_cfg  (zero_cfg),
      .blk_end   (blk_end),
      .last_unit (last_unit)
   );

   dma_seq_addr #(.STD_AW(STD_AW), .ADV_AW(ADV_AW)) u_addr (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (start_ok),
      .ld_addr (ld_addr),
      .ld_adv  (c_adv_en),
      .step    (step),
      .actl    (c_actl),
      .xsize   (xfer_size),
      .addr_q  (cur_addr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         mode_q <= XM_SINGLE;
         done_q <= 1'b0;
         err_q  <= 1'b0;
         blkd_q <= 1'b0;
      end else begin
         blkd_q <= step && blk_end;
         case (st_q)
            ST_IDLE: if (start) begin
               if (zero_cfg) begin
                  err_q <= 1'b1;
               end else begin
                  st_q   <= ST_RUN;
                  mode_q <= xmode_e'(c_mode);
                  err_q  <= 1'b0;
                  done_q <= 1'b0;
               end
            end
            ST_RUN: if (xfer_done) begin
               if (last_unit) begin
                  st_q   <= ST_IDLE;
                  done_q <= 1'b1;
               end else if (mode_q == XM_SINGLE) begin
                  st_q <= ST_WAIT;
               end
            end
            ST_WAIT: if (start) st_q <= ST_RUN;
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign busy      = (st_q == ST_RUN);
   assign blk_done  = blkd_q;
   assign chan_done = done_q;
   assign cfg_err   = err_q;

   // R10: outside a running channel only an accepted start moves the address
   p_idle_addr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q != ST_RUN && !start_ok) |=> $stable(cur_addr));

   // R8: single mode pauses after every counted unit
   p_single_pause_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_RUN && mode_q == XM_SINGLE && xfer_done) |=> (st_q != ST_RUN));

   // R7: a refused start leaves the channel idle
   p_err_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |-> (st_q == ST_IDLE));

   // R6: channel completion in block mode coincides with a block end
   p_final_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(done_q) && mode_q == XM_BLOCK) |-> blkd_q);

   // R11: a finished channel is idle
   p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> (st_q == ST_IDLE));

endmodule

// File: tb/dma_chan_seq_bench.sv
`timescale 1ns/1ps
module dma_chan_seq_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_addr = '0;
   logic [15:0] cfg_wdata = '0;
   logic        start = 1'b0;
   logic        xfer_done = 1'b0;
   logic [1:0]  xfer_size = '0;
   logic [31:0] cur_addr;
   logic        busy, blk_done, chan_done, cfg_err;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   dma_chan_seq u_dma_chan_seq (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .start(start), .xfer_done(xfer_done),
      .xfer_size(xfer_size), .cur_addr(cur_addr), .busy(busy),
      .blk_done(blk_done), .chan_done(chan_done), .cfg_err(cfg_err)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] f_next(logic [31:0] a, logic [1:0] ac,
                                          logic [1:0] sz, logic adv);
      logic [31:0] st, r;
      st = (sz == 2'b00) ? 32'd1 : (sz == 2'b01) ? 32'd2 : 32'd4;
      case (ac)
         2'b01:   r = a + st;
         2'b10:   r = a - st;
         default: r = a;
      endcase
      if (!adv) r[31:28] = 4'h0;
      return r;
   endfunction

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(posedge clk); #1;
      cfg_we = 1'b0;
   endtask

   task automatic pulse_start();
      start = 1'b1;
      @(posedge clk); #1;
      start = 1'b0;
   endtask

   task automatic do_xfer(input logic [1:0] sz);
      xfer_done = 1'b1; xfer_size = sz;
      @(posedge clk); #1;
      xfer_done = 1'b0;
   endtask

   task automatic run_case(input logic [1:0] md, input logic [7:0] bl,
                           input logic [7:0] mid, input logic [7:0] hi,
                           input logic [1:0] ac, input logic [1:0] sz,
                           input logic adv, input logic [15:0] lo,
                           input logic [15:0] ahi);
      logic [31:0] ea;
      int total;
      logic blk, sgl;
      blk = (md == 2'b10);
      sgl = (md == 2'b00);
      wr(3'd6, {15'b0, adv});
      wr(3'd2, lo);
      wr(3'd3, {4'b0, ahi[11:0]});
      wr(3'd4, lo ^ 16'h5A5A);
      wr(3'd5, ahi);
      wr(3'd0, {mid, bl});
      wr(3'd1, {4'b0, ac, md, hi});
      ea = adv ? {ahi, lo ^ 16'h5A5A} : {4'b0, ahi[11:0], lo};
      total = blk ? int'(bl) * int'({hi, mid}) : int'({hi, mid, bl});
      pulse_start();
      chk("R2", "start address", cur_addr, ea);
      chk("R7", "error cleared by start", 32'(cfg_err), 32'd0);
      chk("R9", "busy after start", 32'(busy), 32'd1);
      chk("R11", "done cleared by start", 32'(chan_done), 32'd0);
      for (int u = 1; u <= total; u++) begin
         if (sgl && u > 1) begin
            pulse_start();
            chk("R8", "resume busy", 32'(busy), 32'd1);
            chk("R8", "resume keeps address", cur_addr, ea);
         end else if (!sgl && ($urandom % 4 == 0)) begin
            pulse_start();
            chk("R10", "start while running keeps address", cur_addr, ea);
            chk("R10", "start while running keeps busy", 32'(busy), 32'd1);
         end
         do_xfer(sz);
         ea = f_next(ea, ac, sz, adv);
         chk("R3 R4", "address step", cur_addr, ea);
         chk("R6", "block end pulse", 32'(blk_done),
             32'(blk && ((u % int'(bl)) == 0)));
         chk(blk ? "R6" : "R5", "channel done", 32'(chan_done), 32'(u == total));
         chk(sgl ? "R8" : "R9", "busy", 32'(busy), 32'(!sgl && u != total));
      end
      do_xfer(sz);
      chk("R10", "strobe while idle", cur_addr, ea);
      chk("R11", "done sticky", 32'(chan_done), 32'd1);
      chk("R6", "no block pulse when idle", 32'(blk_done), 32'd0);
   endtask

   initial begin
      int seed;
      seed = int'($urandom(32'h1F2E));
      #12;
      chk("R1", "reset address", cur_addr, 32'd0);
      chk("R1", "reset busy", 32'(busy), 32'd0);
      chk("R1", "reset done", 32'(chan_done), 32'd0);
      chk("R1", "reset err", 32'(cfg_err), 32'd0);
      chk("R1", "reset block pulse", 32'(blk_done), 32'd0);
      rst_n = 1'b1;
      @(posedge clk); #1;

      // R7: zero block length in block mode
      wr(3'd0, {8'd2, 8'd0});
      wr(3'd1, {4'b0, 2'b01, 2'b10, 8'd0});
      pulse_start();
      chk("R7", "zero block length err", 32'(cfg_err), 32'd1);
      chk("R7", "zero block length idle", 32'(busy), 32'd0);
      chk("R7", "zero block length address", cur_addr, 32'd0);
      // R7: zero block count in block mode
      wr(3'd0, {8'd0, 8'd3});
      pulse_start();
      chk("R7", "zero block count err", 32'(cfg_err), 32'd1);
      chk("R7", "zero block count idle", 32'(busy), 32'd0);
      // R7: zero unit count in back-to-back mode
      wr(3'd0, 16'd0);
      wr(3'd1, {4'b0, 2'b01, 2'b01, 8'd0});
      pulse_start();
      chk("R7", "zero count err", 32'(cfg_err), 32'd1);
      chk("R7", "zero count idle", 32'(busy), 32'd0);
      do_xfer(2'b10);
      chk("R10", "strobe after refusal", cur_addr, 32'd0);

      // R4 wraps
      run_case(2'b01, 8'd2, 8'd0, 8'd0, 2'b01, 2'b10, 1'b0, 16'hFFFF, 16'h0FFF);
      run_case(2'b11, 8'd3, 8'd0, 8'd0, 2'b01, 2'b01, 1'b1, 16'hA5A4, 16'hFFFF);
      run_case(2'b00, 8'd2, 8'd0, 8'd0, 2'b10, 2'b00, 1'b0, 16'h0000, 16'hF000);
      // R5: field order of the 24-bit count
      run_case(2'b01, 8'd3, 8'd1, 8'd0, 2'b00, 2'b01, 1'b0, 16'h1234, 16'h0567);
      // R6: high block-count field
      run_case(2'b10, 8'd2, 8'd0, 8'd1, 2'b01, 2'b00, 1'b1, 16'h0100, 16'h8000);
      run_case(2'b10, 8'd3, 8'd2, 8'd0, 2'b10, 2'b01, 1'b1, 16'h0040, 16'h0001);
      run_case(2'b10, 8'd1, 8'd4, 8'd0, 2'b11, 2'b11, 1'b0, 16'hBEEF, 16'h0ABC);

      for (int k = 0; k < 40; k++) begin
         logic [1:0] md;
         logic [7:0] bl, mid;
         md = 2'($urandom % 4);
         if (md == 2'b10) begin
            bl  = 8'(1 + $urandom % 5);
            mid = 8'(1 + $urandom % 3);
         end else begin
            bl  = 8'(1 + $urandom % 12);
            mid = 8'd0;
         end
         run_case(md, bl, mid, 8'd0, 2'($urandom % 4), 2'($urandom % 4),
                  1'($urandom % 2), 16'($urandom), 16'($urandom));
      end

      if (!finished) begin
         finished = 1;
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

endmodule